// File: doc/BRIEF.md
# Dithered Bit-Plane Serializer

This block prepares a vector of unsigned input words for a bit-serial array that works best when every input plane it receives has a roughly constant number of active lanes. A fixed offset is kept for each lane and added to that lane's word. The widened sums then leave the block one bit position at a time, least significant first. Because the offsets look random, each emitted plane has about half of its lanes set, whatever the raw inputs hold. The effect of the offsets is removed downstream by subtracting a precomputed product.

Each lane has one single-bit full adder and one carry flop. The per-lane offsets sit in a small register table that is written lane by lane before use. A vector is taken when the block is idle. The block then emits a fixed number of planes on consecutive cycles. Each plane comes with its index and a count of its set bits, so the load balance can be watched.

Top module: `dither_plane_serializer`

## Requirements
- R1: After reset, busy, plane_valid and done are low, plane_ones is zero, and every lane offset in the table is zero.
- R2: When vec_valid is high while busy is low, the vector on vec_x is taken at that clock edge and busy is high in the following cycle. Lane n occupies bits [n*8 +: 8] of vec_x.
- R3: While busy is high, vec_valid has no effect: the planes in progress are unchanged and no extra planes are produced for the ignored vector.
- R4: With a vector taken at edge E, plane k (k = 0 to 11) is presented at edge E+1+k. Bit n of plane_bits equals bit k of X_n + U_n, where X_n is lane n's input and U_n is the lane's table offset captured at edge E.
- R5: plane_idx carries k with each plane, so the index runs 0, 1, ... 11 on 12 consecutive valid cycles.
- R6: plane_ones equals the number of set bits in plane_bits in the same cycle.
- R7: done is high for exactly one cycle, together with plane 11. In that same cycle busy is low again.
- R8: A table write (tbl_we, tbl_lane, tbl_value, 5-bit value) stores the value for that lane. A write made while a vector is in flight does not change that vector's planes; it applies from the next vector taken.
- R9: Planes with an index of 9 or more are all zero, since an 8-bit input plus a 5-bit offset never reaches bit 9.

Top module port widths below are for the default LANES = 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Write strobe for the offset table |
| tbl_lane | input | 8 | Lane whose offset is written |
| tbl_value | input | 5 | Offset value to store |
| vec_valid | input | 1 | Request to take vec_x |
| vec_x | input | 2048 | Input words, 8 bits per lane |
| busy | output | 1 | A vector is being serialized |
| plane_valid | output | 1 | plane_bits, plane_idx, plane_ones are valid |
| plane_idx | output | 4 | Bit position of the current plane |
| plane_bits | output | 256 | One bit per lane for this position |
| plane_ones | output | 9 | Count of set bits in plane_bits |
| done | output | 1 | The last plane of the vector is valid |

## Verification
The bound checker watches, on every cycle, the relations that need no knowledge of the data. It checks that a request while idle raises busy, that planes start at index zero and step by one without gaps, that the ones count matches the plane, that done comes only with the final plane, and that the top planes stay empty. Whether each bit is really the right bit of the dithered sum, which offset was used, and that ignored requests and mid-run table writes leave the stream alone can only be shown by the bench. It does this by comparing every plane against sums it computes itself for zero, saturated, patterned and random inputs.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_t;
endpackage

// File: rtl/dither_table.sv
module dither_table #(
  parameter int LANES = 256,
  parameter int UW    = 5,
  parameter int AW    = $clog2(LANES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [AW-1:0]         waddr,
  input  logic [UW-1:0]         wdata,
  output logic [LANES*UW-1:0]   u_flat
);
  logic [UW-1:0] mem [LANES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LANES; i++) mem[i] <= '0;
    end else if (we && (int'(waddr) < LANES)) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar n = 0; n < LANES; n++) begin : g_out
    assign u_flat[n*UW +: UW] = mem[n];
  end
endmodule

// File: rtl/serial_lane_adder.sv
module serial_lane_adder #(
  parameter int XW = 8,
  parameter int UW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [XW-1:0] x_in,
  input  logic [UW-1:0] u_in,
  output logic          sum_bit
);
  logic [XW-1:0] x_sh;
  logic [UW-1:0] u_sh;
  logic          carry;
  logic          carry_nx;

  always_comb begin
    sum_bit  = x_sh[0] ^ u_sh[0] ^ carry;
    carry_nx = (x_sh[0] & u_sh[0]) | (carry & (x_sh[0] ^ u_sh[0]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_sh  <= '0;
      u_sh  <= '0;
      carry <= 1'b0;
    end else if (load) begin
      x_sh  <= x_in;
      u_sh  <= u_in;
      carry <= 1'b0;
    end else if (step) begin
      x_sh  <= x_sh >> 1;
      u_sh  <= u_sh >> 1;
      carry <= carry_nx;
    end
  end
endmodule

// File: rtl/plane_popcount.sv
module plane_popcount #(
  parameter int LANES = 256,
  parameter int CW    = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0] bits,
  output logic [CW-1:0]    count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < LANES; i++) count = count + CW'(bits[i]);
  end
endmodule

// File: rtl/plane_sequencer.sv
module plane_sequencer
  import dps_pkg::*;
#(
  parameter int PLANES = 12,
  parameter int IW     = $clog2(PLANES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vec_valid,
  output logic          load,
  output logic          step,
  output logic          last,
  output logic          busy,
  output logic [IW-1:0] idx
);
  run_state_t state;

  always_comb begin
    step = (state == ST_RUN);
    load = vec_valid && (state == ST_IDLE);
    last = step && (idx == IW'(PLANES - 1));
    busy = step;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else if (load) begin
      state <= ST_RUN;
      idx   <= '0;
    end else if (step) begin
      if (last) begin
        state <= ST_IDLE;
        idx   <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dither_plane_serializer.sv
module dither_plane_serializer #(
  parameter int LANES  = 256,
  parameter int XW     = 8,
  parameter int UW     = 5,
  parameter int PLANES = 12,
  parameter int AW     = $clog2(LANES),
  parameter int IW     = $clog2(PLANES),
  parameter int CW     = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tbl_we,
  input  logic [AW-1:0]       tbl_lane,
  input  logic [UW-1:0]       tbl_value,
  input  logic                vec_valid,
  input  logic [LANES*XW-1:0] vec_x,
  output logic                busy,
  output logic                plane_valid,
  output logic [IW-1:0]       plane_idx,
  output logic [LANES-1:0]    plane_bits,
  output logic [CW-1:0]       plane_ones,
  output logic                done
);
  logic [LANES*UW-1:0] u_flat;
  logic [LANES-1:0]    sum_vec;
  logic [CW-1:0]       sum_ones;
  logic                load, step, last;
  logic [IW-1:0]       idx;

  dither_table #(.LANES(LANES), .UW(UW), .AW(AW)) i_table (
    .clk(clk), .rst(rst), .we(tbl_we), .waddr(tbl_lane),
    .wdata(tbl_value), .u_flat(u_flat)
  );

  plane_sequencer #(.PLANES(PLANES), .IW(IW)) i_seq (
    .clk(clk), .rst(rst), .vec_valid(vec_valid), .load(load),
    .step(step), .last(last), .busy(busy), .idx(idx)
  );

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    serial_lane_adder #(.XW(XW), .UW(UW)) i_lane (
      .clk(clk), .rst(rst), .load(load), .step(step),
      .x_in(vec_x[n*XW +: XW]), .u_in(u_flat[n*UW +: UW]),
      .sum_bit(sum_vec[n])
    );
  end

  plane_popcount #(.LANES(LANES), .CW(CW)) i_pop (
    .bits(sum_vec), .count(sum_ones)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      plane_valid <= 1'b0;
      done        <= 1'b0;
      plane_idx   <= '0;
      plane_bits  <= '0;
      plane_ones  <= '0;
    end else begin
      plane_valid <= step;
      done        <= last;
      if (step) begin
        plane_idx  <= idx;
        plane_bits <= sum_vec;
        plane_ones <= sum_ones;
      end
    end
  end
endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
  parameter int LANES     = 256,
  parameter int PLANES    = 12,
  parameter int IW        = 4,
  parameter int CW        = 9,
  parameter int ZERO_FROM = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             vec_valid,
  input logic             busy,
  input logic             plane_valid,
  input logic [IW-1:0]    plane_idx,
  input logic [LANES-1:0] plane_bits,
  input logic [CW-1:0]    plane_ones,
  input logic             done
);
  // R2
  take_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && !busy) |=> busy);

  // R5
  first_plane_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(plane_valid) |-> (plane_idx == '0));

  // R5
  idx_steps_chk: assert property (@(posedge clk) disable iff (rst)
    (plane_valid && plane_idx != IW'(PLANES - 1)) |=>
      (plane_valid && plane_idx == IW'($past(plane_idx) + 1'b1)));

  // R6
  ones_match_chk: assert property (@(posedge clk) disable iff (rst)
    plane_valid |-> (CW'($countones(plane_bits)) == plane_ones));

  // R7
  done_last_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (plane_valid && plane_idx == IW'(PLANES - 1) && !busy));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  high_planes_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (plane_valid && int'(plane_idx) >= ZERO_FROM) |-> (plane_bits == '0));
endmodule

bind dither_plane_serializer dps_checker #(
  .LANES(LANES), .PLANES(PLANES), .IW(IW), .CW(CW),
  .ZERO_FROM(((XW > UW) ? XW : UW) + 1)
) i_dps_checker (
  .clk(clk), .rst(rst), .vec_valid(vec_valid), .busy(busy),
  .plane_valid(plane_valid), .plane_idx(plane_idx),
  .plane_bits(plane_bits), .plane_ones(plane_ones), .done(done)
);

// File: tb/test_dither_plane_serializer.sv
module test_dither_plane_serializer;
  localparam int LANES  = 256;
  localparam int XW     = 8;
  localparam int UW     = 5;
  localparam int PLANES = 12;
  localparam int AW     = $clog2(LANES);
  localparam int IW     = $clog2(PLANES);
  localparam int CW     = $clog2(LANES + 1);

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                tbl_we = 1'b0;
  logic [AW-1:0]       tbl_lane = '0;
  logic [UW-1:0]       tbl_value = '0;
  logic                vec_valid = 1'b0;
  logic [LANES*XW-1:0] vec_x = '0;
  logic                busy, plane_valid, done;
  logic [IW-1:0]       plane_idx;
  logic [LANES-1:0]    plane_bits;
  logic [CW-1:0]       plane_ones;

  always #2 clk = ~clk;

  dither_plane_serializer #(.LANES(LANES), .XW(XW), .UW(UW), .PLANES(PLANES))
    i_dither_plane_serializer (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_lane(tbl_lane),
    .tbl_value(tbl_value), .vec_valid(vec_valid), .vec_x(vec_x),
    .busy(busy), .plane_valid(plane_valid), .plane_idx(plane_idx),
    .plane_bits(plane_bits), .plane_ones(plane_ones), .done(done)
  );

  typedef struct {
    logic [LANES-1:0] bits;
    int               idx;
    bit               last;
  } exp_t;

  exp_t        sb[$];
  int          n_checks = 0;
  int          n_fail   = 0;
  int          tbl_model [LANES];
  logic [XW-1:0] xs [LANES];

  task automatic check(input bit ok, input string tag,
                       input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected planes and compares
  always @(negedge clk) begin
    if (!rst) begin
      if (plane_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R3 plane without a pending vector", LANES'(plane_idx), '0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(plane_bits == e.bits, "R4 plane bits", plane_bits, e.bits);
          check(int'(plane_idx) == e.idx, "R5 plane index", LANES'(plane_idx), LANES'(e.idx));
          check(int'(plane_ones) == $countones(e.bits), "R6 ones count",
                LANES'(plane_ones), LANES'($countones(e.bits)));
          check(done == e.last, "R7 done with last plane", LANES'(done), LANES'(e.last));
          if (e.idx >= 9) check(plane_bits == '0, "R9 high plane empty", plane_bits, '0);
        end
      end else if (done) begin
        check(1'b0, "R7 done without plane", 1, 0);
      end
    end
  end

  task automatic push_expect();
    for (int k = 0; k < PLANES; k++) begin
      exp_t e;
      for (int n = 0; n < LANES; n++) e.bits[n] = 1'(((int'(xs[n]) + tbl_model[n]) >> k) & 1);
      e.idx  = k;
      e.last = (k == PLANES - 1);
      sb.push_back(e);
    end
  endtask

  // Driver (called at a negedge)
  task automatic send_vector();
    while (busy) @(negedge clk);
    vec_valid = 1'b1;
    for (int n = 0; n < LANES; n++) vec_x[n*XW +: XW] = xs[n];
    push_expect();
    @(negedge clk);
    vec_valid = 1'b0;
    check(busy == 1'b1, "R2 busy after take", LANES'(busy), 1);
    check(plane_valid == 1'b0, "R4 no plane in take cycle", LANES'(plane_valid), 0);
  endtask

  task automatic wait_finish();
    while (busy) @(negedge clk);
    @(negedge clk);
    check(sb.size() == 0, "R4 all planes delivered", LANES'(sb.size()), 0);
  endtask

  task automatic tbl_write(input int lane, input int val);
    tbl_we = 1'b1; tbl_lane = AW'(lane); tbl_value = UW'(val);
    @(negedge clk);
    tbl_we = 1'b0;
    tbl_model[lane] = val;
  endtask

  initial begin
    for (int n = 0; n < LANES; n++) tbl_model[n] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !plane_valid && !done && plane_ones == '0, "R1 reset outputs",
          LANES'({busy, plane_valid, done, plane_ones}), 0);

    // R1: cleared table -> zero input yields all-zero planes
    for (int n = 0; n < LANES; n++) xs[n] = '0;
    send_vector(); wait_finish();

    // R8: load random offsets 0..30
    for (int n = 0; n < LANES; n++) tbl_write(n, $urandom_range(0, 30));
    for (int n = 0; n < LANES; n++) xs[n] = XW'($urandom);
    send_vector(); wait_finish();

    for (int n = 0; n < LANES; n++) xs[n] = '1;
    send_vector(); wait_finish();

    for (int n = 0; n < LANES; n++) xs[n] = '0;
    send_vector(); wait_finish();

    for (int n = 0; n < LANES; n++) xs[n] = (n % 2 == 0) ? 8'h55 : 8'hAA;
    send_vector(); wait_finish();

    // R3 and R8: request and table writes during a run
    for (int n = 0; n < LANES; n++) xs[n] = XW'($urandom);
    send_vector();
    vec_valid = 1'b1;
    vec_x = {LANES{8'hC3}};
    @(negedge clk);
    vec_valid = 1'b0;
    tbl_write(3, 31);
    tbl_write(0, 0);
    wait_finish();
    repeat (10) begin
      @(negedge clk);
      check(!plane_valid && !busy, "R3 ignored request left no trace",
            LANES'({plane_valid, busy}), 0);
    end

    // R8: new offsets apply to the next vector; back to back
    for (int n = 0; n < LANES; n++) xs[n] = XW'($urandom);
    send_vector();
    for (int n = 0; n < LANES; n++) xs[n] = XW'($urandom);
    send_vector(); wait_finish();

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule